// File: doc/BRIEF.md
# Floppy Drive Select and Data Rate Output Logic

This block turns the host-visible state of a floppy disk controller into the control lines that leave the chip toward the drives. It holds the digital output register, which carries a two-bit drive number and four motor enable bits. It also holds the current data-rate code, which the host may load through either of two rate registers. From these it produces the active-low drive select lines, a shared select line for drives 2 and 3, the two data-rate pins, a density select whose polarity follows a drive-type identity input, and an idle indication.

A drive is selected only while its own motor enable bit is set. Two strap-like mode inputs change how the select lines are driven. The exchange mode swaps logical drives 0 and 1 onto each other's select line. The four-drive mode turns the select pins into an encoded form that, together with the drive-2-or-3 line, can address four drives. Every output is registered, and a synchronous active-high reset forces all of them inactive.

Top module: `fdd_sel_rate`

## Requirements
- R1: While reset is asserted, and after the first clock edge of reset, drv_sel_n is 2'b11, drv23_sel_n is 1, rate_out is 2'b00, density_sel is 0 and idle_out is 0. The output register (drive number in bits 1:0, motor enables in bits 7:4) and the rate code return to zero.
- R2: With four_drive_en low and exchange_en low, drive number d in {0,1} with its motor bit set drives drv_sel_n[d] low and the other select high. At most one bit of drv_sel_n is ever low in this mode.
- R3: The motor enable for drive number d is bit 4+d of the output register. If that bit is clear, drv_sel_n is 2'b11 and drv23_sel_n is 1, whatever the other motor bits hold.
- R4: With exchange_en high, drive number 0 uses select line 1 and drive number 1 uses select line 0. The motor bit checked is still the one of the written drive number.
- R5: drv23_sel_n goes low when the drive number is 2 or 3 with its motor bit set and exchange_en is low. In two-drive mode both drv_sel_n bits then stay high. drv23_sel_n stays high whenever exchange_en is high.
- R6: With four_drive_en high and the written drive active, the lines are encoded from the drive number p after any exchange. drv_sel_n[0] is 0, drv_sel_n[1] is the inverse of p[0], and drv23_sel_n is the inverse of p[1] (forced high under exchange). With no active drive all three lines are high.
- R7: rate_out equals bits 1:0 of whichever rate register, ccr or dsr, was written most recently. If both are written in the same cycle, the dsr value is taken.
- R8: The rate code means 00 = 500 kbps, 01 = 300 kbps, 10 = 250 kbps and 11 = 1 Mbps. Codes 00 and 11 are high density. density_sel is high for a high density code when ident is 1. It is low for a high density code when ident is 0, and the inverse holds for the low density codes.
- R9: idle_out is high when fdc_idle or fdc_powerdown is high, and low otherwise.
- R10: A register write changes the outputs at the second rising edge after the write is presented. A change on four_drive_en, exchange_en, ident, fdc_idle or fdc_powerdown shows at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| dor_wr | input | 1 | Write strobe for the digital output register |
| dor_wdata | input | 8 | Output register data: drive number 1:0, motor enables 7:4 |
| ccr_wr | input | 1 | Write strobe for the configuration control rate register |
| ccr_wdata | input | 2 | Rate code written through the configuration control register |
| dsr_wr | input | 1 | Write strobe for the data rate select register |
| dsr_wdata | input | 2 | Rate code written through the data rate select register |
| four_drive_en | input | 1 | Encoded four-drive select mode |
| exchange_en | input | 1 | Swap logical drives 0 and 1 |
| ident | input | 1 | Drive-type identity, sets density select polarity |
| fdc_idle | input | 1 | Controller idle state |
| fdc_powerdown | input | 1 | Controller powered-down state |
| drv_sel_n | output | 2 | Active-low drive select lines |
| drv23_sel_n | output | 1 | Active-low drive 2 or 3 select |
| rate_out | output | 2 | Current data-rate code |
| density_sel | output | 1 | Density select |
| idle_out | output | 1 | Idle indication |

## Verification
On every cycle the assertions check the following: reset silences every line, a cleared motor bit keeps all selects high, and exchange mode never drives the drive-2-or-3 line. They also check that two-drive mode never lowers both selects, that the rate code follows the last writer with the dsr taking a tie, and that the idle output tracks its inputs. Only the bench scenarios can show the exact line pattern for each drive number under each mode combination. The same holds for the density polarity across all four codes and both identity values, the two-edge write latency, and a return to defaults after a reset in mid-operation.

// File: rtl/fdd_sel_pkg.sv
package fdd_sel_pkg;

  localparam int RATE_W = 2;

  typedef enum logic [RATE_W-1:0] {
    RATE_500K = 2'b00,
    RATE_300K = 2'b01,
    RATE_250K = 2'b10,
    RATE_1M   = 2'b11
  } rate_e;

  // High density: 500 kbps and 1 Mbps codes.
  function automatic logic is_high_density(input logic [RATE_W-1:0] code);
    return (code == RATE_500K) || (code == RATE_1M);
  endfunction

endpackage

// File: rtl/fdd_dor_reg.sv
module fdd_dor_reg #(
  parameter int DOR_W     = 8,
  parameter int DRV_W     = 2,
  parameter int MOTOR_LSB = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr,
  input  logic [DOR_W-1:0]    wdata,
  output logic [DRV_W-1:0]    drv_num,
  output logic [(1<<DRV_W)-1:0] motor_en
);
  localparam int NDRV = 1 << DRV_W;

  logic unused_bits;
  assign unused_bits = ^wdata[MOTOR_LSB-1:DRV_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_num  <= '0;
      motor_en <= '0;
    end else if (wr) begin
      drv_num  <= wdata[DRV_W-1:0];
      motor_en <= wdata[MOTOR_LSB +: NDRV];
    end
  end

  // R1: register returns to zero after reset
  a_r1_dor_cleared: assert property (@(posedge clk) rst |=> (drv_num == '0 && motor_en == '0));
endmodule

// File: rtl/fdd_rate_track.sv
module fdd_rate_track
  import fdd_sel_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ccr_wr,
  input  logic [RATE_W-1:0] ccr_wdata,
  input  logic              dsr_wr,
  input  logic [RATE_W-1:0] dsr_wdata,
  output logic [RATE_W-1:0] rate_code
);
  // Both rate registers alias one stored code: the later write wins.
  always_ff @(posedge clk) begin
    if (rst)         rate_code <= RATE_500K;
    else if (dsr_wr) rate_code <= dsr_wdata;
    else if (ccr_wr) rate_code <= ccr_wdata;
  end

  a_r7_dsr_takes: assert property (@(posedge clk) disable iff (rst)
    dsr_wr |=> rate_code == $past(dsr_wdata));
  a_r7_ccr_takes: assert property (@(posedge clk) disable iff (rst)
    (ccr_wr && !dsr_wr) |=> rate_code == $past(ccr_wdata));
  a_r7_code_holds: assert property (@(posedge clk) disable iff (rst)
    (!ccr_wr && !dsr_wr) |=> $stable(rate_code));
endmodule

// File: rtl/fdd_sel_decode.sv
module fdd_sel_decode #(
  parameter int DRV_W = 2
) (
  input  logic                  four_drive_en,
  input  logic                  exchange_en,
  input  logic [DRV_W-1:0]      drv_num,
  input  logic [(1<<DRV_W)-1:0] motor_en,
  output logic                  active,
  output logic [1:0]            sel_n,
  output logic                  d23_n
);
  logic [DRV_W-1:0] pdrv;
  logic [1:0]       two_sel_n;
  logic             low_pair;

  assign active   = motor_en[drv_num];
  assign low_pair = (drv_num[DRV_W-1:1] == '0);
  // Exchange swaps only logical drives 0 and 1.
  assign pdrv     = (exchange_en && low_pair) ? (drv_num ^ DRV_W'(1)) : drv_num;

  for (genvar gi = 0; gi < 2; gi++) begin : g_two
    assign two_sel_n[gi] = ~(active && (pdrv == DRV_W'(gi)));
  end

  always_comb begin
    if (four_drive_en) begin
      sel_n[0] = ~active;
      sel_n[1] = ~(active && pdrv[0]);
      d23_n    = ~(active && pdrv[1] && !exchange_en);
    end else begin
      sel_n    = two_sel_n;
      d23_n    = ~(active && !low_pair && !exchange_en);
    end
  end
endmodule

// File: rtl/fdd_sel_rate.sv
module fdd_sel_rate
  import fdd_sel_pkg::*;
#(
  parameter int DOR_W     = 8,
  parameter int DRV_W     = 2,
  parameter int MOTOR_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dor_wr,
  input  logic [DOR_W-1:0]  dor_wdata,
  input  logic              ccr_wr,
  input  logic [RATE_W-1:0] ccr_wdata,
  input  logic              dsr_wr,
  input  logic [RATE_W-1:0] dsr_wdata,
  input  logic              four_drive_en,
  input  logic              exchange_en,
  input  logic              ident,
  input  logic              fdc_idle,
  input  logic              fdc_powerdown,
  output logic [1:0]        drv_sel_n,
  output logic              drv23_sel_n,
  output logic [RATE_W-1:0] rate_out,
  output logic              density_sel,
  output logic              idle_out
);
  localparam int NDRV = 1 << DRV_W;

  logic [DRV_W-1:0]  drv_num;
  logic [NDRV-1:0]   motor_en;
  logic [RATE_W-1:0] rate_code;
  logic              dec_active;
  logic [1:0]        dec_sel_n;
  logic              dec_d23_n;
  logic              dens_nxt;

  fdd_dor_reg #(.DOR_W(DOR_W), .DRV_W(DRV_W), .MOTOR_LSB(MOTOR_LSB)) u_dor (
    .clk(clk), .rst(rst), .wr(dor_wr), .wdata(dor_wdata),
    .drv_num(drv_num), .motor_en(motor_en)
  );

  fdd_rate_track u_rate (
    .clk(clk), .rst(rst),
    .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata),
    .dsr_wr(dsr_wr), .dsr_wdata(dsr_wdata),
    .rate_code(rate_code)
  );

  fdd_sel_decode #(.DRV_W(DRV_W)) u_dec (
    .four_drive_en(four_drive_en), .exchange_en(exchange_en),
    .drv_num(drv_num), .motor_en(motor_en),
    .active(dec_active), .sel_n(dec_sel_n), .d23_n(dec_d23_n)
  );

  // Polarity of density select follows the identity input.
  assign dens_nxt = is_high_density(rate_code) ~^ ident;

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_sel_n   <= 2'b11;
      drv23_sel_n <= 1'b1;
      rate_out    <= RATE_500K;
      density_sel <= 1'b0;
      idle_out    <= 1'b0;
    end else begin
      drv_sel_n   <= dec_sel_n;
      drv23_sel_n <= dec_d23_n;
      rate_out    <= rate_code;
      density_sel <= dens_nxt;
      idle_out    <= fdc_idle | fdc_powerdown;
    end
  end

  a_r1_outputs_quiet: assert property (@(posedge clk)
    rst |=> (drv_sel_n == 2'b11 && drv23_sel_n && rate_out == 2'b00 && !density_sel && !idle_out));
  a_r3_motor_gate: assert property (@(posedge clk) disable iff (rst)
    !dec_active |=> (drv_sel_n == 2'b11 && drv23_sel_n));
  a_r2_single_select: assert property (@(posedge clk) disable iff (rst)
    !four_drive_en |=> $onehot0(~drv_sel_n));
  a_r5_swap_no_d23: assert property (@(posedge clk) disable iff (rst)
    exchange_en |=> drv23_sel_n);
  a_r9_idle_high: assert property (@(posedge clk) disable iff (rst)
    (fdc_idle || fdc_powerdown) |=> idle_out);
  a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
    (!fdc_idle && !fdc_powerdown) |=> !idle_out);
endmodule

// File: tb/tb_fdd_sel_rate.sv
`timescale 1ns/1ps
module tb_fdd_sel_rate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dor_wr = 1'b0;
  logic [7:0] dor_wdata = '0;
  logic       ccr_wr = 1'b0;
  logic [1:0] ccr_wdata = '0;
  logic       dsr_wr = 1'b0;
  logic [1:0] dsr_wdata = '0;
  logic       four_drive_en = 1'b0;
  logic       exchange_en = 1'b0;
  logic       ident = 1'b1;
  logic       fdc_idle = 1'b0;
  logic       fdc_powerdown = 1'b0;
  logic [1:0] drv_sel_n;
  logic       drv23_sel_n;
  logic [1:0] rate_out;
  logic       density_sel;
  logic       idle_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fdd_sel_rate dut (
    .clk(clk), .rst(rst), .dor_wr(dor_wr), .dor_wdata(dor_wdata),
    .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata), .dsr_wr(dsr_wr), .dsr_wdata(dsr_wdata),
    .four_drive_en(four_drive_en), .exchange_en(exchange_en), .ident(ident),
    .fdc_idle(fdc_idle), .fdc_powerdown(fdc_powerdown),
    .drv_sel_n(drv_sel_n), .drv23_sel_n(drv23_sel_n), .rate_out(rate_out),
    .density_sel(density_sel), .idle_out(idle_out)
  );

  // {req, four, exch, dor, exp sel_n, exp d23_n}
  localparam int NV = 17;
  localparam logic [16:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b0, 8'h10, 2'b10, 1'b1},  // R2 drive 0
    {4'd2, 1'b0, 1'b0, 8'h21, 2'b01, 1'b1},  // R2 drive 1
    {4'd3, 1'b0, 1'b0, 8'h01, 2'b11, 1'b1},  // R3 motor off
    {4'd5, 1'b0, 1'b0, 8'h42, 2'b11, 1'b0},  // R5 drive 2
    {4'd5, 1'b0, 1'b0, 8'h83, 2'b11, 1'b0},  // R5 drive 3
    {4'd3, 1'b0, 1'b0, 8'h73, 2'b11, 1'b1},  // R3 other motors only
    {4'd4, 1'b0, 1'b1, 8'h10, 2'b01, 1'b1},  // R4 0 -> line 1
    {4'd4, 1'b0, 1'b1, 8'h21, 2'b10, 1'b1},  // R4 1 -> line 0
    {4'd5, 1'b0, 1'b1, 8'h42, 2'b11, 1'b1},  // R5 no d23 under swap
    {4'd4, 1'b0, 1'b1, 8'h20, 2'b11, 1'b1},  // R4 motor stays logical
    {4'd6, 1'b1, 1'b0, 8'h10, 2'b10, 1'b1},  // R6 drive 0
    {4'd6, 1'b1, 1'b0, 8'h21, 2'b00, 1'b1},  // R6 drive 1
    {4'd6, 1'b1, 1'b0, 8'h42, 2'b10, 1'b0},  // R6 drive 2
    {4'd6, 1'b1, 1'b0, 8'h83, 2'b00, 1'b0},  // R6 drive 3
    {4'd6, 1'b1, 1'b0, 8'h03, 2'b11, 1'b1},  // R6 inactive
    {4'd6, 1'b1, 1'b1, 8'h10, 2'b00, 1'b1},  // R6 swapped 0
    {4'd6, 1'b1, 1'b1, 8'h83, 2'b00, 1'b1}   // R6 drive 3 under swap
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic dor_write(input logic [7:0] v);
    @(negedge clk); dor_wr = 1'b1; dor_wdata = v;
    @(negedge clk); dor_wr = 1'b0;
  endtask

  task automatic rate_write(input logic wc, input logic [1:0] cv,
                            input logic wd, input logic [1:0] dv);
    @(negedge clk); ccr_wr = wc; ccr_wdata = cv; dsr_wr = wd; dsr_wdata = dv;
    @(negedge clk); ccr_wr = 1'b0; dsr_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values while held
    chk("R1 sel_n", drv_sel_n, 2'b11);
    chk("R1 d23_n", drv23_sel_n, 1);
    chk("R1 rate", rate_out, 0);
    chk("R1 density", density_sel, 0);
    chk("R1 idle", idle_out, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 density 500k ident1", density_sel, 1);

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      @(negedge clk);
      four_drive_en = v[12];
      exchange_en = v[11];
      dor_write(v[10:3]);
      repeat (2) @(negedge clk);
      chk($sformatf("R%0d vec%0d sel_n", v[16:13], i), drv_sel_n, v[2:1]);
      chk($sformatf("R%0d vec%0d d23_n", v[16:13], i), drv23_sel_n, v[0]);
    end

    // R10 write latency: old value after first edge, new after second
    four_drive_en = 1'b0; exchange_en = 1'b0;
    dor_write(8'h10);
    repeat (2) @(negedge clk);
    chk("R10 settle", drv_sel_n, 2'b10);
    dor_write(8'h21);
    chk("R10 first edge unchanged", drv_sel_n, 2'b10);
    @(negedge clk);
    chk("R10 second edge", drv_sel_n, 2'b01);
    // R10 mode input latency: one edge
    exchange_en = 1'b1;
    @(negedge clk);
    chk("R10 mode one edge", drv_sel_n, 2'b10);
    exchange_en = 1'b0;

    // R7 / R8 rate and density
    ident = 1'b1;
    rate_write(1, 2'b01, 0, 2'b00);
    chk("R7 ccr 01", rate_out, 2'b01);
    chk("R8 300k ident1", density_sel, 0);
    rate_write(0, 2'b00, 1, 2'b11);
    chk("R7 dsr 11", rate_out, 2'b11);
    chk("R8 1M ident1", density_sel, 1);
    rate_write(1, 2'b10, 0, 2'b00);
    chk("R7 ccr after dsr", rate_out, 2'b10);
    chk("R8 250k ident1", density_sel, 0);
    ident = 1'b0;
    @(negedge clk);
    chk("R8 250k ident0", density_sel, 1);
    rate_write(1, 2'b01, 1, 2'b00);
    chk("R7 same cycle dsr wins", rate_out, 2'b00);
    chk("R8 500k ident0", density_sel, 0);
    ident = 1'b1;

    // R9 idle
    fdc_idle = 1'b1; @(negedge clk);
    chk("R9 idle", idle_out, 1);
    fdc_idle = 1'b0; fdc_powerdown = 1'b1; @(negedge clk);
    chk("R9 powerdown", idle_out, 1);
    fdc_powerdown = 1'b0; @(negedge clk);
    chk("R9 busy", idle_out, 0);

    // R1 reset in mid-run
    rate_write(1, 2'b10, 0, 2'b00);
    dor_write(8'h10);
    fdc_idle = 1'b1;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 mid sel_n", drv_sel_n, 2'b11);
    chk("R1 mid idle", idle_out, 0);
    chk("R1 mid rate", rate_out, 0);
    rst = 1'b0; fdc_idle = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 dor default", drv_sel_n, 2'b11);
    chk("R1 rate default", rate_out, 0);
    chk("R1 density after", density_sel, 1);

    finish_run();
  end
endmodule